// File: doc/BRIEF.md
# Linked-List Sum Walker

This engine adds up the value fields of a singly linked list held in memory. Software or a neighbouring block supplies the address of the first element and pulses a start input. The engine then reads each element through a plain request/response read port and adds its value into a running total. It follows the link stored in each element to find the next one, and stops when it reads a link of zero. When it finishes, it raises a one-cycle completion pulse and holds the 64-bit total at its output until the next run begins.

Each element takes two words of memory. The value word sits at the element's own address, and the link word sits a fixed byte offset above it. Each read address depends on data returned by the previous read, so the engine never has more than one read in flight. A run over N elements costs 2N reads plus their memory latency. The total is plain modular addition, so the order of accumulation has no effect on the result.

Top module: `chain_sum_engine`

## Requirements
- R1: After reset the engine is idle, with `busy_o`, `done_o` and `rd_req_o` all low and `sum_o` equal to zero.
- R2: A start with `head_i` equal to zero finishes without issuing any read. On the next cycle `done_o` pulses, `busy_o` stays low and `sum_o` is zero.
- R3: For an element at address A, the engine first reads the value at A and then reads the link at A + NEXT_OFF (8 bytes by default). The next element's address is the link word, truncated to ADDR_W bits.
- R4: `rd_req_o` is high for one cycle per read. A new request is never issued while an earlier read is still waiting for its `rd_valid_i` response.
- R5: A link word that is zero across all DATA_W bits ends the walk. The result is then the sum of the value words of every element visited, starting from the head.
- R6: The sum is a DATA_W-bit two's-complement total that wraps on overflow and raises no flag.
- R7: A start pulse that arrives while `busy_o` is high is ignored. The run in progress, its read addresses and its result are unchanged.
- R8: `done_o` is high for exactly one cycle, and `busy_o` is already low in that cycle. While the engine is idle, `sum_o` stays stable until the next accepted start.
- R9: A start with a nonzero head raises `busy_o` from the next cycle, and `busy_o` stays high until the cycle of `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a walk; taken only while idle |
| head_i | input | ADDR_W | Byte address of the first element, or zero for an empty list |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| sum_o | output | DATA_W | Total of the value words |
| rd_req_o | output | 1 | One-cycle read request |
| rd_addr_o | output | ADDR_W | Byte address of the read |
| rd_valid_i | input | 1 | Read data is present on `rd_data_i` |
| rd_data_i | input | DATA_W | Read data word |

## Verification
The bench builds the engine with DATA_W = 64 and ADDR_W = 16. This selects the narrowing path, in which a 64-bit link word becomes a 16-bit address while the end-of-list test still looks at all 64 bits. With a 16-bit address space, a small memory model can hold lists of up to 40 elements scattered out of address order. The model's random read latency of one to three cycles tests the single-outstanding-read rule, and lists built from large or negative values force the total to wrap.

// File: rtl/chain_sum_pkg.sv
package chain_sum_pkg;

   typedef enum logic [2:0] {
      WK_IDLE     = 3'd0,
      WK_VAL_REQ  = 3'd1,
      WK_VAL_WAIT = 3'd2,
      WK_LNK_REQ  = 3'd3,
      WK_LNK_WAIT = 3'd4
   } walk_state_t;

   typedef struct packed {
      logic acc_clr;
      logic acc_add;
      logic ptr_from_head;
      logic ptr_from_link;
      logic sel_link;
      logic rd_req;
      logic finish;
   } walk_ctl_t;

endpackage

// File: rtl/chain_sum_seq.sv
module chain_sum_seq
   import chain_sum_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   input  logic        head_zero_i,
   input  logic        rsp_valid_i,
   input  logic        link_zero_i,
   output walk_ctl_t   ctl_o,
   output logic        busy_o,
   output logic        done_o
);

   walk_state_t state_q, state_d;
   logic        done_q;

   always_comb begin
      state_d = state_q;
      ctl_o   = '0;
      unique case (state_q)
         WK_IDLE: begin
            if (start_i) begin
               ctl_o.acc_clr = 1'b1;
               if (head_zero_i) begin
                  ctl_o.finish = 1'b1;
               end else begin
                  ctl_o.ptr_from_head = 1'b1;
                  state_d = WK_VAL_REQ;
               end
            end
         end
         WK_VAL_REQ: begin
            ctl_o.rd_req = 1'b1;
            state_d      = WK_VAL_WAIT;
         end
         WK_VAL_WAIT: begin
            if (rsp_valid_i) begin
               ctl_o.acc_add = 1'b1;
               state_d       = WK_LNK_REQ;
            end
         end
         WK_LNK_REQ: begin
            ctl_o.rd_req   = 1'b1;
            ctl_o.sel_link = 1'b1;
            state_d        = WK_LNK_WAIT;
         end
         WK_LNK_WAIT: begin
            ctl_o.sel_link = 1'b1;
            if (rsp_valid_i) begin
               if (link_zero_i) begin
                  ctl_o.finish = 1'b1;
                  state_d      = WK_IDLE;
               end else begin
                  ctl_o.ptr_from_link = 1'b1;
                  state_d             = WK_VAL_REQ;
               end
            end
         end
         default: state_d = WK_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WK_IDLE;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= ctl_o.finish;
      end
   end

   assign busy_o = (state_q != WK_IDLE);
   assign done_o = done_q;

endmodule

// File: rtl/chain_sum_ptr.sv
module chain_sum_ptr
   import chain_sum_pkg::*;
#(
   parameter int unsigned ADDR_W   = 64,
   parameter int unsigned DATA_W   = 64,
   parameter int unsigned NEXT_OFF = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  walk_ctl_t         ctl_i,
   input  logic [ADDR_W-1:0] head_i,
   input  logic [DATA_W-1:0] rsp_data_i,
   output logic [ADDR_W-1:0] rd_addr_o
);

   localparam logic [ADDR_W-1:0] LinkOfs = ADDR_W'(NEXT_OFF);

   logic [ADDR_W-1:0] node_q;
   logic [ADDR_W-1:0] link_addr;

   generate
      if (ADDR_W == DATA_W) begin : g_full_ptr
         assign link_addr = rsp_data_i;
      end else begin : g_narrow_ptr
         assign link_addr = rsp_data_i[ADDR_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         node_q <= '0;
      end else if (ctl_i.ptr_from_head) begin
         node_q <= head_i;
      end else if (ctl_i.ptr_from_link) begin
         node_q <= link_addr;
      end
   end

   assign rd_addr_o = ctl_i.sel_link ? (node_q + LinkOfs) : node_q;

endmodule

// File: rtl/chain_sum_acc.sv
module chain_sum_acc
   import chain_sum_pkg::*;
#(
   parameter int unsigned DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  walk_ctl_t         ctl_i,
   input  logic [DATA_W-1:0] rsp_data_i,
   output logic [DATA_W-1:0] sum_o
);

   logic [DATA_W-1:0] acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (ctl_i.acc_clr) begin
         acc_q <= '0;
      end else if (ctl_i.acc_add) begin
         acc_q <= acc_q + rsp_data_i;
      end
   end

   assign sum_o = acc_q;

endmodule

// File: rtl/chain_sum_engine.sv
module chain_sum_engine
   import chain_sum_pkg::*;
#(
   parameter int unsigned DATA_W   = 64,
   parameter int unsigned ADDR_W   = 64,
   parameter int unsigned NEXT_OFF = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] head_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] sum_o,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic              rd_valid_i,
   input  logic [DATA_W-1:0] rd_data_i
);

   generate
      if (ADDR_W > DATA_W || ADDR_W < 4) begin : g_bad_addr_w
         $error("chain_sum_engine: ADDR_W must be between 4 and DATA_W");
      end
      if (NEXT_OFF == 0 || NEXT_OFF >= (1 << (ADDR_W > 30 ? 30 : ADDR_W))) begin : g_bad_off
         $error("chain_sum_engine: NEXT_OFF must be nonzero and fit in ADDR_W");
      end
   endgenerate

   walk_ctl_t ctl;
   logic      head_zero;
   logic      link_zero;

   assign head_zero = (head_i == '0);
   assign link_zero = (rd_data_i == '0);

   chain_sum_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .head_zero_i (head_zero),
      .rsp_valid_i (rd_valid_i),
      .link_zero_i (link_zero),
      .ctl_o       (ctl),
      .busy_o      (busy_o),
      .done_o      (done_o)
   );

   chain_sum_ptr #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .NEXT_OFF (NEXT_OFF)
   ) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_i      (ctl),
      .head_i     (head_i),
      .rsp_data_i (rd_data_i),
      .rd_addr_o  (rd_addr_o)
   );

   chain_sum_acc #(
      .DATA_W (DATA_W)
   ) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_i      (ctl),
      .rsp_data_i (rd_data_i),
      .sum_o      (sum_o)
   );

   assign rd_req_o = ctl.rd_req;

endmodule

// File: rtl/chain_sum_checker.sv
module chain_sum_checker #(
   parameter int unsigned DATA_W   = 64,
   parameter int unsigned ADDR_W   = 64,
   parameter int unsigned NEXT_OFF = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [ADDR_W-1:0] head_i,
   input logic              busy_o,
   input logic              done_o,
   input logic [DATA_W-1:0] sum_o,
   input logic              rd_req_o,
   input logic [ADDR_W-1:0] rd_addr_o,
   input logic              rd_valid_i
);

   logic              pend_q;
   logic              pair_q;
   logic [ADDR_W-1:0] last_addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         pair_q      <= 1'b0;
         last_addr_q <= '0;
      end else begin
         if (rd_req_o) pend_q <= 1'b1;
         else if (rd_valid_i) pend_q <= 1'b0;
         if (start_i && !busy_o) pair_q <= 1'b0;
         else if (rd_req_o) pair_q <= ~pair_q;
         if (rd_req_o) last_addr_q <= rd_addr_o;
      end
   end

   // R1: idle and cleared on the first edge after reset release
   assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (!busy_o && !done_o && !rd_req_o && sum_o == '0));

   // R2: empty list finishes at once with zero
   assert_null_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i && head_i == '0) |=> (done_o && !busy_o && sum_o == '0));

   // R3: link read sits NEXT_OFF above the value read of the same element
   assert_link_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && pair_q) |-> (rd_addr_o == last_addr_q + ADDR_W'(NEXT_OFF)));

   // R4: single-cycle requests, never two outstanding
   assert_req_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |=> !rd_req_o);
   assert_one_outstanding_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |-> !pend_q);

   // R8: done is a lone pulse outside busy, result stable while idle
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
   assert_sum_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !$past(busy_o) && !$past(start_i)) |-> $stable(sum_o));

   // R9: nonzero head raises busy on the next cycle
   assert_busy_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i && head_i != '0) |=> busy_o);
   assert_req_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |-> busy_o);

endmodule

bind chain_sum_engine chain_sum_checker #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .NEXT_OFF (NEXT_OFF)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .head_i     (head_i),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .sum_o      (sum_o),
   .rd_req_o   (rd_req_o),
   .rd_addr_o  (rd_addr_o),
   .rd_valid_i (rd_valid_i)
);

// File: tb/chain_sum_engine_bench.sv
`timescale 1ns/1ps
module chain_sum_engine_bench;

   localparam int DW = 64;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] head = '0;
   logic          busy_o, done_o, rd_req_o;
   logic [DW-1:0] sum_o;
   logic [AW-1:0] rd_addr_o;
   logic          rd_valid = 1'b0;
   logic [DW-1:0] rd_data = '0;

   int total = 0;
   int bad = 0;
   int m_chk = 0;
   int m_bad = 0;

   logic [DW-1:0] mem [512];

   always #2 clk = ~clk;

   chain_sum_engine #(.DATA_W(DW), .ADDR_W(AW), .NEXT_OFF(8)) u_chain_sum_engine (
      .clk(clk), .rst_n(rst_n), .start_i(start), .head_i(head),
      .busy_o(busy_o), .done_o(done_o), .sum_o(sum_o),
      .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
      .rd_valid_i(rd_valid), .rd_data_i(rd_data));

   // memory model with random latency and address-sequence check
   logic          pend = 1'b0;
   logic          phase = 1'b0;
   logic [1:0]    lat = '0;
   logic [AW-1:0] raddr = '0;
   logic [AW-1:0] exp_a = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         pend <= 1'b0; rd_valid <= 1'b0; phase <= 1'b0;
      end else begin
         rd_valid <= 1'b0;
         if (start && !busy_o) begin
            exp_a <= head; phase <= 1'b0;
         end
         if (rd_req_o) begin
            m_chk++;
            if (pend) begin
               m_bad++;
               $display("FAIL R4: request while read pending, actual=1 expected=0");
            end
            m_chk++;
            if (rd_addr_o != exp_a) begin
               m_bad++;
               $display("FAIL R3: read address actual=%h expected=%h", rd_addr_o, exp_a);
            end
            pend <= 1'b1; lat <= 2'($urandom_range(2, 0)); raddr <= rd_addr_o;
         end else if (pend) begin
            if (lat == 0) begin
               rd_valid <= 1'b1;
               rd_data  <= mem[raddr[11:3]];
               pend     <= 1'b0;
               if (!phase) exp_a <= raddr + 16'd8;
               else        exp_a <= mem[raddr[11:3]][AW-1:0];
               phase <= ~phase;
            end else begin
               lat <= lat - 2'd1;
            end
         end
      end
   end

   function automatic logic [DW-1:0] ref_sum(input logic [DW-1:0] p);
      if (p == '0) return '0;
      return mem[p[11:3]] + ref_sum(mem[p[11:3] + 9'd1]);
   endfunction

   task automatic check(input logic ok, input string req, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // lay out n elements at scattered even word slots; mode picks values
   task automatic build(input int n, input int rot, input int mode, output logic [AW-1:0] h);
      logic [AW-1:0] a [];
      a = new[n];
      for (int i = 0; i < n; i++) a[i] = AW'((((rot + i * 37) % 200) + 1) * 16);
      for (int i = 0; i < n; i++) begin
         case (mode)
            1:       mem[a[i][11:3]] = 64'h7FFF_FFFF_FFFF_FF00 + 64'(i);
            2:       mem[a[i][11:3]] = -64'($urandom_range(1000, 1));
            default: mem[a[i][11:3]] = {$urandom, $urandom};
         endcase
         mem[a[i][11:3] + 9'd1] = (i == n - 1) ? 64'd0 : 64'(a[i + 1]);
      end
      h = (n == 0) ? '0 : a[0];
   endtask

   task automatic run(input logic [AW-1:0] h, input string req, input logic inject,
                      input logic [AW-1:0] other);
      logic [DW-1:0] exp;
      logic [DW-1:0] held;
      int n;
      exp = ref_sum(64'(h));
      @(negedge clk); start = 1'b1; head = h;
      @(negedge clk); start = 1'b0;
      if (h != '0) check(busy_o == 1'b1, "R9", 64'(busy_o), 64'd1);
      n = 0;
      while (!done_o && n < 20000) begin
         if (inject && n == 4) begin start = 1'b1; head = other; end
         else start = 1'b0;
         @(negedge clk);
         n++;
      end
      start = 1'b0;
      check(done_o == 1'b1, "R8", 64'(done_o), 64'd1);
      check(sum_o == exp, req, sum_o, exp);
      check(busy_o == 1'b0, "R8", 64'(busy_o), 64'd0);
      held = sum_o;
      @(negedge clk);
      check(done_o == 1'b0, "R8", 64'(done_o), 64'd0);
      repeat (4) @(negedge clk);
      check(sum_o == held, "R8", sum_o, held);
   endtask

   initial begin
      logic [AW-1:0] h, h2;
      void'($urandom(32'd1234));
      for (int i = 0; i < 512; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy_o == 1'b0, "R1", 64'(busy_o), 64'd0);
      check(done_o == 1'b0, "R1", 64'(done_o), 64'd0);
      check(rd_req_o == 1'b0, "R1", 64'(rd_req_o), 64'd0);
      check(sum_o == '0, "R1", sum_o, 64'd0);

      // R2: empty list
      @(negedge clk); start = 1'b1; head = '0;
      @(negedge clk); start = 1'b0;
      check(done_o == 1'b1, "R2", 64'(done_o), 64'd1);
      check(busy_o == 1'b0, "R2", 64'(busy_o), 64'd0);
      check(sum_o == '0, "R2", sum_o, 64'd0);
      @(negedge clk);
      check(done_o == 1'b0, "R2", 64'(done_o), 64'd0);

      // R5: single element, then random lists
      build(1, 7, 0, h);  run(h, "R5", 1'b0, '0);
      for (int k = 0; k < 16; k++) begin
         build($urandom_range(40, 1), $urandom_range(199, 0), 0, h);
         run(h, "R5", 1'b0, '0);
      end
      // R6: wrap with large positives and with negatives
      build(12, 3, 1, h);  run(h, "R6", 1'b0, '0);
      build(9, 50, 2, h);  run(h, "R6", 1'b0, '0);
      // R7: start during busy is ignored
      build(6, 100, 0, h2);
      build(10, 11, 0, h);
      run(h, "R7", 1'b1, h2);

      // a fresh start after idle clears the old total
      build(3, 160, 2, h);  run(h, "R5", 1'b0, '0);

      repeat (4) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total + m_chk, bad + m_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total + m_chk + 1, bad + m_bad + 1);
      $finish;
   end

endmodule